// File: doc/BRIEF.md
# Mixed-Trigger Interrupt Status Controller

This block gathers interrupt request lines from peripherals into one status word that software reads over a small register bus. Each source is set up on its own as edge-triggered or level-triggered. An edge source keeps a sticky flag that is set when its request rises. Software clears that flag by writing a one to its bit. A level source mirrors the peripheral's request line. Software writes do not touch it, and it clears when the peripheral drops its request.

Edge and level sources can sit next to each other in the same status word. Writing ones clears only edge flags, and a zero bit changes nothing, so no read-modify-write sequence and no separate acknowledge register are needed.

A per-source enable word gates the status bits into a single registered interrupt line for the processor. Every request input first passes through a synchronizer.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status word (address 0), the trigger-select word (address 1), the enable word (address 2) and `irq_o` all read 0. With trigger-select at 0, every source is level-triggered.
- R2: In edge mode (trigger-select bit = 1), a rising edge on a request sets that source's status bit. The bit stays set after the request falls.
- R3: Writing a 1 to address 0 clears the status bit of an edge-mode source.
- R4: Writing a 0 to a status bit leaves that bit unchanged.
- R5: In level mode (trigger-select bit = 0), the status bit follows the request line after the synchronizer delay. Writes of 1 or 0 to that bit have no effect.
- R6: If a rising edge and a write of 1 reach an edge-mode bit in the same cycle, the bit ends up set.
- R7: `irq_o` is a register. Its value is the OR of (status AND enable) from the cycle before. The enable word does not change what the status word reads.
- R8: Addresses 1 and 2 read back the last value written to them. Any other address, apart from 0, reads 0.
- R9: A single all-ones write to address 0 clears every edge-mode bit and leaves every level-mode bit as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_SRC | Peripheral request lines (asynchronous) |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | NUM_SRC | Write data |
| rd_data_o | output | NUM_SRC | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Registered interrupt to the processor |

## Verification
The bench builds the block with NUM_SRC = 6 and SYNC_STAGES = 2. With six sources it can hold edge and level sources side by side: four edge and two level. It can also keep one level source active while masked and another while enabled, so the mixed clear and the gating are both visible in one status word. With two synchronizer stages the bench can place a rising edge and a clearing write in exactly the same cycle, which is what the set-wins case needs.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_STATUS  = 2'd0,
    REG_TRIGSEL = 2'd1,
    REG_ENABLE  = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic req_s_i,   // synchronized request
  input  logic edge_mode_i,
  input  logic clr_i,     // write-one-to-clear strike on this bit
  output logic rise_o,
  output logic status_o
);
  logic req_d_q;
  logic flag_q;

  assign rise_o = req_s_i & ~req_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      req_d_q <= req_s_i;
      if (!edge_mode_i) flag_q <= 1'b0;
      else              flag_q <= (flag_q & ~clr_i) | rise_o;
    end
  end

  assign status_o = edge_mode_i ? flag_q : req_s_i;

  // R3: a clear with no competing edge empties the flag
  a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    $past(edge_mode_i && clr_i && !rise_o) |-> !flag_q);
  // R4: no clear strike keeps a set flag set
  a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    $past(edge_mode_i && !clr_i && flag_q) |-> flag_q);
  // R6: a rising edge always sets, even against a clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(edge_mode_i && rise_o) |-> flag_q);
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] enable_i,
  output logic         irq_o
);
  function automatic logic any_enabled(input logic [W-1:0] s, input logic [W-1:0] e);
    return |(s & e);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= any_enabled(status_i, enable_i);
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = REG_ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wr_data_i,
  output logic [NUM_SRC-1:0] rd_data_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] req_s;
  logic [NUM_SRC-1:0] trigsel_q, enable_q;
  logic [NUM_SRC-1:0] status, rise, clr_strike;
  logic               wr_status, wr_trigsel, wr_enable;

  assign wr_status  = wr_en_i && (addr_i == ADDR_W'(REG_STATUS));
  assign wr_trigsel = wr_en_i && (addr_i == ADDR_W'(REG_TRIGSEL));
  assign wr_enable  = wr_en_i && (addr_i == ADDR_W'(REG_ENABLE));
  assign clr_strike = wr_status ? wr_data_i : '0;

  irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(req_i), .q_o(req_s)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_src_cell u_cell (
      .clk(clk), .rst_n(rst_n), .req_s_i(req_s[g]), .edge_mode_i(trigsel_q[g]),
      .clr_i(clr_strike[g]), .rise_o(rise[g]), .status_o(status[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trigsel_q <= '0;
      enable_q  <= '0;
    end else begin
      if (wr_trigsel) trigsel_q <= wr_data_i;
      if (wr_enable)  enable_q  <= wr_data_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_W'(REG_STATUS):  rd_data_o = status;
      ADDR_W'(REG_TRIGSEL): rd_data_o = trigsel_q;
      ADDR_W'(REG_ENABLE):  rd_data_o = enable_q;
      default:              rd_data_o = '0;
    endcase
  end

  irq_combine #(.W(NUM_SRC)) u_combine (
    .clk(clk), .rst_n(rst_n), .status_i(status), .enable_i(enable_q), .irq_o(irq_o)
  );

  // R7: the processor line reflects the enabled status of the prior cycle
  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(status & enable_q)));
  // R5: a level-mode bit tracks its synchronized request
  a_r5_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    ((status ^ req_s) & ~trigsel_q) == '0);
  // R1: right after reset the outputs are quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> !irq_o);
endmodule

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_i = '0;
  logic [1:0]   addr_i = '0;
  logic         wr_en_i = 1'b0;
  logic [N-1:0] wr_data_i = '0;
  logic [N-1:0] rd_data_o;
  logic         irq_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {
    bit           is_irq;
    logic [N-1:0] exp;
    string        tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  irq_status_ctrl #(.NUM_SRC(N), .SYNC_STAGES(2)) i_irq_status_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  // monitor: pops expectations and compares away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [N-1:0] act;
      it = sb_q.pop_front();
      act = it.is_irq ? N'(irq_o) : rd_data_o;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic exp_rd(logic [1:0] a, logic [N-1:0] e, string tag);
    @(posedge clk); #1;
    addr_i = a;
    sb_q.push_back('{is_irq: 1'b0, exp: e, tag: tag});
    @(negedge clk); #1;
  endtask

  task automatic exp_irq(logic e, string tag);
    @(posedge clk); #1;
    sb_q.push_back('{is_irq: 1'b1, exp: N'(e), tag: tag});
    @(negedge clk); #1;
  endtask

  task automatic wr(logic [1:0] a, logic [N-1:0] d);
    @(posedge clk); #1;
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(posedge clk); #1;
    wr_en_i = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    exp_rd(2'd0, '0, "R1 status");
    exp_rd(2'd1, '0, "R1 trigsel");
    exp_rd(2'd2, '0, "R1 enable");
    exp_irq(1'b0, "R1 irq");

    // sources 0..3 edge, 4..5 level
    wr(2'd1, 6'b001111);
    wr(2'd2, 6'b111111);
    exp_rd(2'd1, 6'b001111, "R8 trigsel readback");
    exp_rd(2'd2, 6'b111111, "R8 enable readback");
    exp_rd(2'd3, '0, "R8 unused address");

    // edge pulse on source 0
    req_i[0] = 1'b1; cyc(3); req_i[0] = 1'b0; cyc(5);
    exp_rd(2'd0, 6'b000001, "R2 edge flag sticky");
    exp_irq(1'b1, "R7 irq from edge");
    wr(2'd0, 6'b000000);
    exp_rd(2'd0, 6'b000001, "R4 zero write keeps");
    wr(2'd0, 6'b000001);
    exp_rd(2'd0, 6'b000000, "R3 w1c clears");
    cyc(2);
    exp_irq(1'b0, "R7 irq drops");

    // level source 4
    req_i[4] = 1'b1; cyc(4);
    exp_rd(2'd0, 6'b010000, "R5 level follows high");
    wr(2'd0, 6'b010000);
    exp_rd(2'd0, 6'b010000, "R5 write ignored");
    req_i[4] = 1'b0; cyc(4);
    exp_rd(2'd0, 6'b000000, "R5 level follows low");

    // masking: source 5 level high, disabled
    wr(2'd2, 6'b011111);
    req_i[5] = 1'b1; cyc(4);
    exp_rd(2'd0, 6'b100000, "R7 status independent of enable");
    exp_irq(1'b0, "R7 masked source silent");
    wr(2'd2, 6'b100000);
    cyc(2);
    exp_irq(1'b1, "R7 enabled source drives irq");

    // mixed clear: edges 1,2 plus level 4,5
    req_i[1] = 1'b1; req_i[2] = 1'b1; req_i[4] = 1'b1; cyc(5);
    exp_rd(2'd0, 6'b110110, "R9 mixed before clear");
    wr(2'd0, 6'b111111);
    exp_rd(2'd0, 6'b110000, "R9 only edges cleared");
    req_i = '0; cyc(5);
    exp_rd(2'd0, 6'b000000, "R9 levels drop with inputs");

    // set wins: flag of source 3 set, then new rise meets a clear
    req_i[3] = 1'b1; cyc(5); req_i[3] = 1'b0; cyc(5);
    exp_rd(2'd0, 6'b001000, "R6 flag armed");
    @(posedge clk); #1; req_i[3] = 1'b1;     // sampled at edge k
    @(posedge clk);                            // edge k
    @(posedge clk); #1;                        // edge k+1: rise pulse now live
    addr_i = 2'd0; wr_data_i = 6'b001000; wr_en_i = 1'b1;
    @(posedge clk); #1; wr_en_i = 1'b0;        // edge k+2: set and clear meet
    exp_rd(2'd0, 6'b001000, "R6 set beats clear");
    wr(2'd0, 6'b001000);
    exp_rd(2'd0, 6'b000000, "R3 later clear works");

    cyc(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule